// File: doc/BRIEF.md
# Streaming 2D FIR Filter Built from Separable Levels

This block convolves a raster image with a fixed 9×9 kernel while the image streams in, one pixel per clock. The kernel is not realised as one full multiply-accumulate array. It is split into `LEVELS` separable levels and one residual level. Each separable level filters a column of nine pixels vertically. It then filters the last nine vertical results horizontally, so it needs 9 + 9 constant products instead of 81. The residual level is a full 9×9 kernel, but its coefficients are only `RES_CW` bits wide, so its 81 products stay cheap. All levels read the same eight line stores, so each input row is stored only once.

Pixels arrive in raster order. `frame_start`, when given together with `in_valid`, marks the top-left pixel of a new frame. Reset has the same effect on the position. When the input at row y, column x is accepted, the window covers rows y-8..y and columns x-8..x. A result is produced when y ≥ 4 and x ≥ 4, and it belongs to the kernel centre (y-4, x-4). Rows above the image and columns left of the image count as zero. The sum is kept at full precision, then arithmetically shifted right by `SHIFT` bits and saturated to a signed `OUT_W`-bit value.

A three-state fill controller tracks how far the window has entered the frame:
- PH_PRIME: rows 0..3; no output.
- PH_EDGE: rows 4..7; output, with the top rows masked.
- PH_STEADY: rows 8 and above; no row masking.

Its transitions are:
- PRIME→EDGE when the last pixel of row 3 is accepted.
- EDGE→STEADY when the last pixel of row 7 is accepted.
- Any state→PRIME on an accepted frame start, or on reset.

Top module: `sepfir2d`

## Requirements
- R1: For the input accepted at (y, x) with y ≥ 4 and x ≥ 4, the result is floor(S / 2^SHIFT) saturated to signed OUT_W. Here S = Σ over k, j in 0..8 of K[k][j]·p(y-8+k, x-8+j). K[k][j] = Σ over levels l of col_l[k]·row_l[j] + res[k][j], with the coefficients given by the package functions `col_coef`, `row_coef` and `res_coef`.
- R2: A result is presented (out_valid high) in the cycle after the second clock edge that follows the edge accepting its pixel.
- R3: Exactly one result is produced for each accepted pixel with y ≥ 4 and x ≥ 4, in input order, and none for any other pixel.
- R4: Samples in rows above row 0 or in columns left of column 0 contribute zero.
- R5: An accepted pixel with frame_start high is position (0, 0). Data from earlier frames has no effect on the later results. Results already in flight still come out.
- R6: A cycle with in_valid low moves no position, window or line store, and produces no result.
- R7: Results above 2^(OUT_W-1)-1 become that value, and results below -2^(OUT_W-1) become that value.
- R8: out_pix holds its last result while out_valid is low.
- R9: After reset, out_valid and out_pix are 0, and the next accepted pixel is (0, 0) without a frame start.
- R10: After LINE_W accepted pixels, the next pixel is column 0 of the next row. Pixels at the end of a row do not enter the left columns of the next row's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel is present this cycle |
| frame_start | input | 1 | With in_valid: this pixel is the first of a frame |
| in_pix | input | PIX_W | Unsigned input pixel |
| out_valid | output | 1 | Result present |
| out_pix | output | OUT_W | Signed, shifted and saturated result |

## Verification
The riskiest overlap is a new frame start that enters while results from the previous frame are still in the three-stage pipeline. The restart must clear the position and the row masks without dropping or corrupting those results. The bench provokes this by issuing a frame start directly after a partial frame, in the middle of a row. It judges every result against a direct 9×9 sum, taken in order from one expected queue that spans both frames. The second overlap is an input gap next to a row wrap. The bench judges it the same way, inserting gaps at pseudo-random points, row ends included.

// File: rtl/sepfir_pkg.sv
package sepfir_pkg;

    // Kernel edge length and centre offset.
    localparam int KSZ = 9;
    localparam int CTR = (KSZ - 1) / 2;

    // Fill phase of the window inside the frame.
    typedef enum logic [1:0] {
        PH_PRIME  = 2'd0,
        PH_EDGE   = 2'd1,
        PH_STEADY = 2'd2
    } phase_t;

    // Vertical taps of separable level lvl (k = 0 is the oldest row).
    function automatic int col_coef(int lvl, int k);
        int d;
        d = k - CTR;
        if (lvl == 0) return 64 - 7 * d * d;
        return 3 * d + lvl;
    endfunction

    // Horizontal taps of separable level lvl (j = 0 is the oldest column).
    function automatic int row_coef(int lvl, int j);
        int d;
        d = j - CTR;
        if (lvl == 0) return 48 - 5 * d * d;
        return 7 * d - lvl;
    endfunction

    // Narrow residual kernel.
    function automatic int res_coef(int k, int j);
        return ((3 * k + 5 * j) % 7) - 3;
    endfunction

endpackage

// File: rtl/sepfir_linestore.sv
module sepfir_linestore
    import sepfir_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int PIX_W  = 8,
    parameter int XW     = 6
) (
    input  logic                         clk,
    input  logic                         shift_en,
    input  logic [XW-1:0]                x_pos,
    input  logic [PIX_W-1:0]             din,
    output logic [KSZ-1:0][PIX_W-1:0]    col_o
);
    localparam int ROWS = KSZ - 1;

    // mem[0] holds the previous row, mem[ROWS-1] the oldest row.
    logic [PIX_W-1:0] mem [ROWS][LINE_W];

    always_ff @(posedge clk) begin
        if (shift_en) begin
            mem[0][x_pos] <= din;
            for (int r = 1; r < ROWS; r++) begin
                mem[r][x_pos] <= mem[r-1][x_pos];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < ROWS; k++) begin
            col_o[k] = mem[ROWS-1-k][x_pos];
        end
        col_o[KSZ-1] = din;
    end
endmodule

// File: rtl/sepfir_level.sv
module sepfir_level
    import sepfir_pkg::*;
#(
    parameter int LVL    = 0,
    parameter int PIX_W  = 8,
    parameter int SEP_CW = 10,
    parameter int VW     = 23,
    parameter int HW     = 37
) (
    input  logic                       clk,
    input  logic                       shift_en,
    input  logic [KSZ-1:0][PIX_W-1:0]  col_i,
    input  logic [KSZ-1:0]             cmask,
    output logic signed [HW-1:0]       hsum
);
    logic signed [VW-1:0]     pe  [KSZ];
    logic signed [SEP_CW-1:0] cv  [KSZ];
    logic signed [SEP_CW-1:0] rv  [KSZ];
    logic signed [VW-1:0]     vsum;
    logic signed [VW-1:0]     hsr [KSZ];

    for (genvar t = 0; t < KSZ; t++) begin : g_tap
        assign pe[t] = $signed({{(VW-PIX_W){1'b0}}, col_i[t]});
        assign cv[t] = SEP_CW'(col_coef(LVL, t));
        assign rv[t] = SEP_CW'(row_coef(LVL, t));
    end

    // Vertical 1D filter over the masked column.
    always_comb begin
        vsum = '0;
        for (int k = 0; k < KSZ; k++) begin
            vsum = vsum + pe[k] * cv[k];
        end
    end

    // Horizontal history of vertical results; hsr[KSZ-1] is the newest.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            for (int j = 0; j < KSZ - 1; j++) begin
                hsr[j] <= hsr[j+1];
            end
            hsr[KSZ-1] <= vsum;
        end
    end

    // Horizontal 1D filter; columns outside the image are dropped.
    always_comb begin
        hsum = '0;
        for (int j = 0; j < KSZ; j++) begin
            if (cmask[j]) hsum = hsum + hsr[j] * rv[j];
        end
    end
endmodule

// File: rtl/sepfir_residual.sv
module sepfir_residual
    import sepfir_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int RES_CW = 4,
    parameter int RW     = 20
) (
    input  logic                       clk,
    input  logic                       shift_en,
    input  logic [KSZ-1:0][PIX_W-1:0]  col_i,
    input  logic [KSZ-1:0]             cmask,
    output logic signed [RW-1:0]       rsum
);
    logic [PIX_W-1:0]         win [KSZ][KSZ];
    logic signed [RES_CW-1:0] rc  [KSZ][KSZ];

    for (genvar k = 0; k < KSZ; k++) begin : g_row
        for (genvar j = 0; j < KSZ; j++) begin : g_col
            assign rc[k][j] = RES_CW'(res_coef(k, j));
        end
    end

    always_ff @(posedge clk) begin
        if (shift_en) begin
            for (int k = 0; k < KSZ; k++) begin
                for (int j = 0; j < KSZ - 1; j++) begin
                    win[k][j] <= win[k][j+1];
                end
                win[k][KSZ-1] <= col_i[k];
            end
        end
    end

    always_comb begin
        rsum = '0;
        for (int k = 0; k < KSZ; k++) begin
            for (int j = 0; j < KSZ; j++) begin
                if (cmask[j]) begin
                    rsum = rsum + $signed({{(RW-PIX_W){1'b0}}, win[k][j]}) * rc[k][j];
                end
            end
        end
    end
endmodule

// File: rtl/sepfir2d.sv
module sepfir2d
    import sepfir_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int PIX_W  = 8,
    parameter int LEVELS = 2,
    parameter int SEP_CW = 10,
    parameter int RES_CW = 4,
    parameter int SHIFT  = 12,
    parameter int OUT_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    frame_start,
    input  logic [PIX_W-1:0]        in_pix,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_pix
);
    localparam int XW    = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int YW    = $clog2(KSZ);
    localparam int VW    = PIX_W + SEP_CW + 5;
    localparam int HW    = VW + SEP_CW + 4;
    localparam int RW    = PIX_W + RES_CW + 8;
    localparam int ACC_W = HW + $clog2(LEVELS + 1) + 1;
    localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OMIN = -OMAX - 1;

    // Position and fill phase.
    logic [XW-1:0] x_q, cur_x, x1;
    logic [YW-1:0] y_q, cur_y;
    phase_t        ph_q, ph_cur, ph_nxt;
    logic          row_end, emit;
    logic [KSZ-1:0] rmask, cmask;

    always_comb begin
        cur_x   = frame_start ? '0 : x_q;
        cur_y   = frame_start ? '0 : y_q;
        ph_cur  = frame_start ? PH_PRIME : ph_q;
        row_end = (cur_x == XW'(LINE_W - 1));
    end

    always_comb begin
        ph_nxt = ph_cur;
        unique case (ph_cur)
            PH_PRIME:  if (row_end && cur_y == YW'(CTR - 1)) ph_nxt = PH_EDGE;
            PH_EDGE:   if (row_end && cur_y == YW'(KSZ - 2)) ph_nxt = PH_STEADY;
            PH_STEADY: ph_nxt = PH_STEADY;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_PRIME;
            x_q  <= '0;
            y_q  <= '0;
        end else if (in_valid) begin
            ph_q <= ph_nxt;
            x_q  <= row_end ? '0 : cur_x + 1'b1;
            y_q  <= (row_end && cur_y != YW'(KSZ - 1)) ? cur_y + 1'b1 : cur_y;
        end
    end

    // Output process of the fill controller: emit and row mask.
    always_comb begin
        emit = in_valid && (ph_cur != PH_PRIME) && (cur_x >= XW'(CTR));
        for (int k = 0; k < KSZ; k++) begin
            rmask[k] = (ph_cur == PH_STEADY) ||
                       (({1'b0, cur_y} + (YW+1)'(k)) >= (YW+1)'(KSZ - 1));
        end
    end

    // Shared line stores and the masked column.
    logic [KSZ-1:0][PIX_W-1:0] col_raw, col_m;

    sepfir_linestore #(.LINE_W(LINE_W), .PIX_W(PIX_W), .XW(XW)) lines_i (
        .clk(clk), .shift_en(in_valid), .x_pos(cur_x), .din(in_pix), .col_o(col_raw)
    );

    always_comb begin
        for (int k = 0; k < KSZ; k++) begin
            col_m[k] = rmask[k] ? col_raw[k] : '0;
        end
    end

    // Stage 1 tags.
    logic v1;
    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            x1 <= '0;
        end else begin
            v1 <= emit;
            if (in_valid) x1 <= cur_x;
        end
    end

    for (genvar j = 0; j < KSZ; j++) begin : g_cmask
        assign cmask[j] = ({1'b0, x1} + (XW+1)'(j)) >= (XW+1)'(KSZ - 1);
    end

    // Separable levels and residual.
    logic signed [HW-1:0] hs [LEVELS];
    logic signed [RW-1:0] rs;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        sepfir_level #(.LVL(l), .PIX_W(PIX_W), .SEP_CW(SEP_CW), .VW(VW), .HW(HW)) lvl_i (
            .clk(clk), .shift_en(in_valid), .col_i(col_m), .cmask(cmask), .hsum(hs[l])
        );
    end

    sepfir_residual #(.PIX_W(PIX_W), .RES_CW(RES_CW), .RW(RW)) res_i (
        .clk(clk), .shift_en(in_valid), .col_i(col_m), .cmask(cmask), .rsum(rs)
    );

    // Stage 2: full-precision sum.
    logic signed [ACC_W-1:0] tot, acc, sh, sat;
    logic v2;

    always_comb begin
        tot = ACC_W'(rs);
        for (int l = 0; l < LEVELS; l++) begin
            tot = tot + ACC_W'(hs[l]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2  <= 1'b0;
            acc <= '0;
        end else begin
            v2 <= v1;
            if (v1) acc <= tot;
        end
    end

    // Stage 3: scale and saturate.
    always_comb begin
        sh = acc >>> SHIFT;
        if (sh > OMAX)      sat = OMAX;
        else if (sh < OMIN) sat = OMIN;
        else                sat = sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= v2;
            if (v2) out_pix <= OUT_W'(sat);
        end
    end
endmodule

// File: rtl/sepfir2d_chk.sv
module sepfir2d_chk
    import sepfir_pkg::*;
#(
    parameter int OUT_W = 11
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    frame_start,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_pix,
    input phase_t                  ph_q
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    assert_prime_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !frame_start && ph_q == PH_PRIME) |=> ##2 !out_valid);

    assert_frame_row0_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && frame_start) |=> ##2 !out_valid);

    assert_gap_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##2 !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_pix));

    assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_pix == '0 && ph_q == PH_PRIME));
endmodule

bind sepfir2d sepfir2d_chk #(.OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
    .out_valid(out_valid), .out_pix(out_pix), .ph_q(ph_q)
);

// File: tb/sepfir2d_tb_top.sv
module sepfir2d_tb_top;
    import sepfir_pkg::*;

    localparam int LW = 12;
    localparam int PW = 8;
    localparam int LV = 2;
    localparam int SH = 12;
    localparam int OW = 11;
    localparam int HI = (1 << (OW - 1)) - 1;
    localparam int LO = -(1 << (OW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic frame_start = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic out_valid;
    logic signed [OW-1:0] out_pix;

    always #5 clk = ~clk;

    sepfir2d #(.LINE_W(LW), .PIX_W(PW), .LEVELS(LV), .SEP_CW(10), .RES_CW(4),
               .SHIFT(SH), .OUT_W(OW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    int kern [KSZ][KSZ];
    int img  [16][LW];
    int cy, cx;
    int exp_q [$];
    int n_chk = 0, n_fail = 0, sat_hi = 0, sat_lo = 0, last_out = 0;
    int unsigned seed = 32'h1234_5678;
    string tag = "R9";
    bit done = 1'b0;

    function automatic int lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    // Direct 9x9 sum of the combined kernel (R1, R4).
    function automatic int expect_at(int y, int x);
        longint s = 0;
        longint q;
        for (int k = 0; k < KSZ; k++) begin
            for (int j = 0; j < KSZ; j++) begin
                if (y - 8 + k >= 0 && x - 8 + j >= 0)
                    s += longint'(kern[k][j]) * img[y-8+k][x-8+j];
            end
        end
        q = s >>> SH;
        if (q > HI) q = HI;
        if (q < LO) q = LO;
        return int'(q);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gen(int mode);
        case (mode)
            0: return lcg() & 255;
            1: return ((cy == 0 && cx == 0) || (cy == 2 && cx == LW-1) ||
                       (cy == 5 && cx == LW-1) || (cy == 6 && cx == 0) ||
                       (cy == 8 && cx == 6) || (cy == 11 && cx == LW-1)) ? 255 : 0;
            3: return lcg() & 3;
            4: return 255;
            default: return ((cy % 8) == 0 || (cx % 8) == 0) ? 255 : 0;
        endcase
    endfunction

    task automatic put(int p, bit fs);
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_pix = PW'(p);
        frame_start = fs;
        if (fs) begin
            cy = 0;
            cx = 0;
            for (int r = 0; r < 16; r++) for (int c = 0; c < LW; c++) img[r][c] = 0;
        end
        img[cy][cx] = p;
        if (cy >= CTR && cx >= CTR) begin
            e = expect_at(cy, cx);
            exp_q.push_back(e);
            if (e == HI) sat_hi++;
            if (e == LO) sat_lo++;
        end
        cx++;
        if (cx == LW) begin
            cx = 0;
            cy++;
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            frame_start = 1'b0;
        end
    endtask

    task automatic send(int mode, int n, bit fs_first, bit gappy);
        for (int i = 0; i < n; i++) begin
            if (gappy && (lcg() % 3) == 0) idle(1 + lcg() % 3);
            if (fs_first && i == 0) begin
                cy = 0;
                cx = 0;
            end
            put(gen(mode), fs_first && i == 0);
        end
    endtask

    // Output monitor: every result against the queue (R1, R3).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3: got unexpected result %0d expected none", out_pix);
            end else begin
                chk(tag, int'(out_pix), exp_q.pop_front());
            end
            last_out = int'(out_pix);
        end
    end

    initial begin
        repeat (KSZ * 0 + 1) begin end
        for (int k = 0; k < KSZ; k++) begin
            for (int j = 0; j < KSZ; j++) begin
                kern[k][j] = res_coef(k, j);
                for (int l = 0; l < LV; l++) kern[k][j] += col_coef(l, k) * row_coef(l, j);
            end
        end
        for (int r = 0; r < 16; r++) for (int c = 0; c < LW; c++) img[r][c] = 0;
        cy = 0;
        cx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", int'(out_valid), 0);
        chk("R9", int'(out_pix), 0);

        // R9: first frame without frame start; R1 on full-range data.
        tag = "R9";
        send(0, 12 * LW, 1'b0, 1'b0);
        // R4 and R10: impulses at edges and row ends.
        tag = "R4 R10";
        send(1, 12 * LW, 1'b1, 1'b0);
        // R6: random gaps.
        tag = "R6";
        send(0, 12 * LW, 1'b1, 1'b1);
        // R7: saturation both ways.
        tag = "R7";
        send(4, 12 * LW, 1'b1, 1'b0);
        send(5, 12 * LW, 1'b1, 1'b0);
        // R5: restart mid-row while results drain.
        tag = "R5";
        send(0, 5 * LW + 7, 1'b1, 1'b0);
        send(3, 12 * LW, 1'b1, 1'b0);
        // R2: exact latency of an isolated pixel at (5,4).
        tag = "R2";
        send(3, 5 * LW + 4, 1'b1, 1'b0);
        idle(6);
        put(gen(3), 1'b0);
        idle(1);
        chk("R2", int'(out_valid), 0);
        idle(1);
        chk("R2", int'(out_valid), 0);
        idle(1);
        chk("R2", int'(out_valid), 1);
        // R8: output holds through a gap.
        idle(5);
        chk("R8", int'(out_valid), 0);
        chk("R8", int'(out_pix), last_out);
        tag = "R1";
        send(3, 12 * LW - (5 * LW + 5), 1'b0, 1'b0);
        idle(8);
        chk("R3", exp_q.size(), 0);
        chk("R7", int'(sat_hi > 0), 1);
        chk("R7", int'(sat_lo > 0), 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3: watchdog expired, got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule